// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands one bit position per clock. It uses a single full adder, a carry flip-flop and two right-shifting registers. Both operands are loaded in parallel. A start pulse then runs the shift sequence for exactly as many clocks as the operand width. On each of these clocks the full adder combines the low bits of both registers with the stored carry. The sum bit enters the top of the augend register, so when the sequence ends that register holds the result and the carry flip-flop holds the carry-out.

The addend register's serial input is set by a parameter. It either recirculates its own low bit, which restores the addend after a full pass, or takes in zeros. With recirculation, a second start without a new load adds the same addend to the previous result. A one-cycle done pulse marks the clock at which the result and carry are valid.

Top module: `bit_serial_adder`

## Requirements
- R1: After reset, `sum_o` is all zeros and `carry_o` and `done_o` are 0.
- R2: A `load_i` accepted while idle puts `augend_i` on `sum_o` and clears `carry_o`, both visible after the next clock edge. The addend is captured in the same edge.
- R3: A `start_i` accepted while idle (and without `load_i` in the same cycle) causes exactly WIDTH shift clocks. `done_o` rises WIDTH clock edges after the edge that took the start.
- R4: When `done_o` is high, `{carry_o, sum_o}` equals the (WIDTH+1)-bit unsigned sum of the loaded augend and addend.
- R5: `done_o` is high for exactly one cycle per addition.
- R6: `start_i` while an addition runs is ignored: the timing of `done_o` and the result are unchanged.
- R7: `load_i` while an addition runs is ignored: the result still uses the operands loaded before the start.
- R8: With KEEP_ADDEND=1 the addend register recirculates. A second start without a reload clears the carry and yields `{carry_o, sum_o}` = previous `sum_o` + addend.
- R9: While idle with neither `load_i` nor `start_i`, `sum_o` and `carry_o` hold their values.
- R10: On each shift, bit WIDTH-1 of the augend register takes the XOR of both low bits and the stored carry. After the first shift of an addition, `sum_o[WIDTH-1]` = augend[0] XOR addend[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Parallel load of both operands (idle only) |
| start_i | input | 1 | Begin a serial addition (idle only) |
| augend_i | input | WIDTH | Augend operand |
| addend_i | input | WIDTH | Addend operand |
| sum_o | output | WIDTH | Augend register; holds the result after done |
| carry_o | output | 1 | Carry flip-flop; final carry-out after done |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
A load becomes visible on `sum_o` one edge after it is accepted. After a start, the first shifted bit appears one edge after the start edge, and `done_o`, the sum and the carry are all due exactly WIDTH edges after it. The bench drives and samples on falling edges and counts those edges from the start. At WIDTH-1 it checks that `done_o` is still low, at WIDTH it checks the pulse and the values, and one edge later it checks that the pulse has dropped. Ignored starts and loads are injected in the middle of a run, and the bench confirms that the pulse timing and the result do not move.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/sa_full_adder.sv
module sa_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  always_comb begin
    s_o = a_i ^ b_i ^ c_i;
    c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  end
endmodule

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (load_i)  q_q <= d_i;
    else if (shift_i) q_q <= {ser_i, q_q[WIDTH-1:1]};
  end

  assign q_o = q_q;

  assert_load_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(d_i));

  assert_shift_entry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> q_o[WIDTH-1] == $past(ser_i));
endmodule

// File: rtl/sa_seq_ctrl.sv
module sa_seq_ctrl
  import serial_add_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic load_i,
  output logic shift_o,
  output logic start_go_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last_c;

  assign last_c     = (ph_q == PH_RUN) && (cnt_q == LAST);
  assign start_go_o = start_i && !load_i && (ph_q == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_c;
      if (start_go_o) begin
        ph_q  <= PH_RUN;
        cnt_q <= '0;
      end else if (ph_q == PH_RUN) begin
        if (last_c) begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign shift_o = (ph_q == PH_RUN);
  assign done_o  = done_q;

  assert_done_after_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(cnt_q) == LAST) && !shift_o);

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && start_i && cnt_q != LAST) |=> shift_o && (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder #(
  parameter int WIDTH       = 8,
  parameter bit KEEP_ADDEND = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             start_i,
  input  logic [WIDTH-1:0] augend_i,
  input  logic [WIDTH-1:0] addend_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             done_o
);
  logic             shift_en, start_go, load_go;
  logic [WIDTH-1:0] a_q, b_q;
  logic             b_ser, fa_s, fa_c, carry_q;

  sa_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .load_i    (load_i),
    .shift_o   (shift_en),
    .start_go_o(start_go),
    .done_o    (done_o)
  );

  // loads are locked out during a run
  assign load_go = load_i && !shift_en;

  generate
    if (KEEP_ADDEND) begin : g_recirc
      assign b_ser = b_q[0];
    end else begin : g_zero_fill
      assign b_ser = 1'b0;
    end
  endgenerate

  sa_full_adder u_fa (
    .a_i(a_q[0]),
    .b_i(b_q[0]),
    .c_i(carry_q),
    .s_o(fa_s),
    .c_o(fa_c)
  );

  sa_shift_reg #(.WIDTH(WIDTH)) u_areg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_go),
    .shift_i(shift_en),
    .d_i    (augend_i),
    .ser_i  (fa_s),
    .q_o    (a_q)
  );

  sa_shift_reg #(.WIDTH(WIDTH)) u_breg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_go),
    .shift_i(shift_en),
    .d_i    (addend_i),
    .ser_i  (b_ser),
    .q_o    (b_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  carry_q <= 1'b0;
    else if (load_go || start_go) carry_q <= 1'b0;
    else if (shift_en)            carry_q <= fa_c;
  end

  assign sum_o   = a_q;
  assign carry_o = carry_q;

  assert_load_clears_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !shift_en) |=> !carry_o && sum_o == $past(augend_i));

  assert_load_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && shift_en) |=> sum_o[WIDTH-2:0] == $past(sum_o[WIDTH-1:1]));

  assert_addend_rotate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en && !load_i) |=>
      b_q == {(KEEP_ADDEND ? $past(b_q[0]) : 1'b0), $past(b_q[WIDTH-1:1])});

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en && !load_i && !start_i) |=> $stable(sum_o) && $stable(carry_o));
endmodule

// File: tb/tb_bit_serial_adder.sv
module tb_bit_serial_adder;
  localparam int W = 8;
  localparam time HALF = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] augend_i = '0;
  logic [W-1:0] addend_i = '0;
  logic [W-1:0] sum_o;
  logic         carry_o;
  logic         done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  bit_serial_adder #(.WIDTH(W), .KEEP_ADDEND(1'b1)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .start_i(start_i),
    .augend_i(augend_i), .addend_i(addend_i),
    .sum_o(sum_o), .carry_o(carry_o), .done_o(done_o)
  );

  always #HALF clk_i = ~clk_i;

  function automatic logic [W:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk_i);
    load_i = 1'b1; augend_i = a; addend_i = b;
    @(negedge clk_i);
    load_i = 1'b0;
    check(sum_o == a && !carry_o, "R2", {carry_o, sum_o}, {1'b0, a});
  endtask

  // start, wait W edges, check timing and value; inj: 0 none, 1 start mid-run, 2 load mid-run
  task automatic run_add(input logic [W:0] exp, input int inj, input string req);
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 1; i < W; i++) begin
      if (i == 2 && inj == 1) start_i = 1'b1;
      if (i == 2 && inj == 2) begin load_i = 1'b1; augend_i = ~augend_i; addend_i = ~addend_i; end
      if (i == 3) begin start_i = 1'b0; load_i = 1'b0; end
      @(negedge clk_i);
    end
    check(!done_o, {req, " R3 early"}, done_o, 0);
    @(negedge clk_i);
    check(done_o, {req, " R3 done"}, done_o, 1);
    check({carry_o, sum_o} == exp, {req, " R4"}, {carry_o, sum_o}, exp);
    @(negedge clk_i);
    check(!done_o, "R5", done_o, 0);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b;
    logic [W:0]   s;
    void'($urandom(32'h5eed_0042));
    #(HALF * 3);
    check(sum_o == '0 && !carry_o && !done_o, "R1", {done_o, carry_o, sum_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed corners
    do_load('0, '0);         run_add(ref_add('0, '0), 0, "zeros");
    do_load('1, '1);         run_add(ref_add('1, '1), 0, "ones");
    do_load(8'hAA, 8'h55);   run_add(ref_add(8'hAA, 8'h55), 0, "alt");
    do_load(8'h55, 8'h55);   run_add(ref_add(8'h55, 8'h55), 0, "alt2");
    do_load('1, 8'h01);      run_add(ref_add('1, 8'h01), 0, "wrap");

    // R10: first shifted bit
    do_load(8'h03, 8'h01);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i);
    check(sum_o[W-1] == 1'b0, "R10 first", sum_o[W-1], 0);
    for (int i = 2; i <= W; i++) @(negedge clk_i);
    check({carry_o, sum_o} == ref_add(8'h03, 8'h01), "R10 final", {carry_o, sum_o}, ref_add(8'h03, 8'h01));
    do_load(8'h02, 8'h03);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i);
    check(sum_o[W-1] == 1'b1, "R10 first b", sum_o[W-1], 1);
    for (int i = 2; i <= W; i++) @(negedge clk_i);

    // R6 / R7
    do_load(8'h9C, 8'h7B);   run_add(ref_add(8'h9C, 8'h7B), 1, "R6");
    do_load(8'hF0, 8'h33);   run_add(ref_add(8'hF0, 8'h33), 2, "R7");

    // R8: re-add circulated addend, then R9 hold
    do_load(8'hC8, 8'h64);
    s = ref_add(8'hC8, 8'h64);
    run_add(s, 0, "R8 first");
    run_add(ref_add(s[W-1:0], 8'h64), 0, "R8 again");
    s = ref_add(s[W-1:0], 8'h64);
    for (int i = 0; i < 5; i++) @(negedge clk_i);
    check({carry_o, sum_o} == s, "R9", {carry_o, sum_o}, s);

    // random
    for (int n = 0; n < 60; n++) begin
      a = W'($urandom);
      b = W'($urandom);
      do_load(a, b);
      run_add(ref_add(a, b), 0, "rand");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule